// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. It takes one virtual address at a time and walks a two-level page table held in memory. It reads the first-level entry through a request/response memory port. If that entry is present, it reads the second-level entry from the table the first entry points to. The walk then ends in one of two ways: a refill record (virtual page number, physical page number and permission bits) for the translation cache, or a fault record that names the failing address and the level at which a non-present entry was found. The walker makes no attempt to recover from a non-present entry.

A root register holds the physical page number of the current first-level table. Software reloads it through a plain load strobe whenever the active process changes. Each walk latches the root value that is current when its miss is accepted.

All data paths use valid/ready. The miss input, the memory request, the memory response, the refill output and the fault output each complete a transfer only on a clock edge where valid and ready are both high. Any of them can be held off for any number of cycles. A producer keeps valid high and its payload unchanged until the transfer completes. Memory response latency is unbounded.

Top module: `ptw_top`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `mem_rsp_ready`, `refill_valid` and `fault_valid` are all 0.
- R2: A miss is accepted on an edge where `miss_valid` and `miss_ready` are both high. `miss_ready` then stays low until the walk's refill or fault has been handed off, so only one walk is in flight at a time.
- R3: In the cycle after acceptance, the walker issues its first memory request at address `root*4096 + va[31:22]*4`, where `root` is the root page number latched at acceptance.
- R4: A memory request keeps `mem_req_valid` high and its address unchanged until `mem_req_ready` is seen. `mem_rsp_ready` is high only while a response is awaited, and a response after any delay is taken.
- R5: When the first-level entry has bit 0 (present) clear, the walk issues no second request. It ends in a fault with `fault_vaddr` equal to the missed address and `fault_level` equal to 1.
- R6: When the first-level entry is present, the second request goes to `e1[31:12]*4096 + va[21:12]*4`, where `e1` is that entry.
- R7: When the second-level entry has bit 0 clear, the walk ends in a fault with `fault_level` equal to 2, even if its other bits are set.
- R8: When the second-level entry `e2` is present, the walk ends with `refill_vpn = va[31:12]`, `refill_ppn = e2[31:12]` and `refill_perm = e2[4:1]` (bit 0 read, bit 1 write, bit 2 dirty, bit 3 user). These are held until `refill_ready`, after which the walker is idle again.
- R9: A fault is held with stable payload until `fault_ready`, after which the walker is idle again. `fault_level` is only ever 1 or 2 while `fault_valid` is high.
- R10: A pulse on `root_load` replaces the root page number with `root_ppn`. A walk already in progress keeps the root it started with, and the next walk uses the new root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_load | input | 1 | Load strobe for the root register |
| root_ppn | input | 20 | Physical page number of the new first-level table |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_ready | output | 1 | Walker awaiting read data |
| mem_rsp_data | input | 32 | Page table entry read from memory |
| refill_valid | output | 1 | Refill record present |
| refill_ready | input | 1 | Translation cache takes the refill |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_ppn | output | 20 | Physical page number of the refill |
| refill_perm | output | 4 | Permission and usage bits {user, dirty, write, read} |
| fault_valid | output | 1 | Fault record present |
| fault_ready | input | 1 | Consumer takes the fault |
| fault_vaddr | output | 32 | Virtual address whose walk failed |
| fault_level | output | 2 | Table level of the non-present entry (1 or 2) |

## Verification
A wrong state or a lost table base shows at the memory port in the cycle after acceptance or after the first response. It appears as a missing request, a second request where none is due, or a request to the wrong address. A wrong choice between refill and fault, a wrong level, or a corrupted page number shows on the first cycle the outcome is presented. A walker that does not return to idle shows on the following cycle, because `miss_ready` stays low. A payload that drifts under back-pressure is visible on any held cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned WALK_LEVELS = 2;

  // Entry bit positions
  localparam int unsigned PTE_BIT_V = 0;
  localparam int unsigned PTE_BIT_R = 1;
  localparam int unsigned PTE_BIT_W = 2;
  localparam int unsigned PTE_BIT_D = 3;
  localparam int unsigned PTE_BIT_U = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_REFILL  = 3'd5,
    ST_FAULT   = 3'd6
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_L1   = 2'd1,
    FLT_L2   = 2'd2
  } flt_lvl_e;
endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
  parameter int unsigned PPN_W   = 20,
  parameter logic [PPN_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PPN_W-1:0] din,
  output logic [PPN_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned LEVELS    = 2,
  parameter int unsigned PTE_BYTES = 4,
  localparam int unsigned LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned PPN_W    = PA_W - OFF_W
) (
  input  logic [VA_W-1:OFF_W] vpn,
  input  logic [PPN_W-1:0]    base_ppn,
  input  logic [LVL_W-1:0]    lvl,
  output logic [PA_W-1:0]     ent_addr
);
  localparam int unsigned ENT_SH = $clog2(PTE_BYTES);

  logic [IDX_W-1:0] idx [LEVELS];

  // Level 0 takes the top index field, later levels the fields below it
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx[g] = vpn[VA_W-1-g*IDX_W -: IDX_W];
  end

  assign ent_addr = {base_ppn, {OFF_W{1'b0}}}
                  + PA_W'({idx[lvl], {ENT_SH{1'b0}}});
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     miss_valid,
  input  logic     req_ready,
  input  logic     rsp_valid,
  input  logic     rsp_present,
  input  logic     refill_ready,
  input  logic     fault_ready,
  output walk_st_e st
);
  walk_st_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:    if (miss_valid)   nxt = ST_L1_REQ;
      ST_L1_REQ:  if (req_ready)    nxt = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid)    nxt = rsp_present ? ST_L2_REQ : ST_FAULT;
      ST_L2_REQ:  if (req_ready)    nxt = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid)    nxt = rsp_present ? ST_REFILL : ST_FAULT;
      ST_REFILL:  if (refill_ready) nxt = ST_IDLE;
      ST_FAULT:   if (fault_ready)  nxt = ST_IDLE;
      default:                      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PTE_BYTES = 4,
  localparam int unsigned PPN_W    = PA_W - OFF_W,
  localparam int unsigned VPN_W    = VA_W - OFF_W,
  localparam int unsigned PTE_BITS = PTE_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                root_load,
  input  logic [PPN_W-1:0]    root_ppn,
  input  logic                miss_valid,
  output logic                miss_ready,
  input  logic [VA_W-1:0]     miss_vaddr,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [PTE_BITS-1:0] mem_rsp_data,
  output logic                refill_valid,
  input  logic                refill_ready,
  output logic [VPN_W-1:0]    refill_vpn,
  output logic [PPN_W-1:0]    refill_ppn,
  output logic [3:0]          refill_perm,
  output logic                fault_valid,
  input  logic                fault_ready,
  output logic [VA_W-1:0]     fault_vaddr,
  output logic [1:0]          fault_level
);
  walk_st_e         st;
  logic [PPN_W-1:0] root_q;
  logic [PPN_W-1:0] base_q;
  logic [PPN_W-1:0] ppn_q;
  logic [VA_W-1:0]  va_q;
  logic [3:0]       perm_q;
  flt_lvl_e         lvl_q;
  logic             present;
  logic             accept;
  logic             l1_take;
  logic             l2_take;
  logic             unused_pte_bits;

  ptw_root_reg #(.PPN_W(PPN_W)) u_root (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (root_load),
    .din   (root_ppn),
    .q     (root_q)
  );

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .req_ready    (mem_req_ready),
    .rsp_valid    (mem_rsp_valid),
    .rsp_present  (present),
    .refill_ready (refill_ready),
    .fault_ready  (fault_ready),
    .st           (st)
  );

  ptw_index #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .OFF_W     (OFF_W),
    .IDX_W     (IDX_W),
    .LEVELS    (WALK_LEVELS),
    .PTE_BYTES (PTE_BYTES)
  ) u_index (
    .vpn      (va_q[VA_W-1:OFF_W]),
    .base_ppn (base_q),
    .lvl      (st == ST_L2_REQ),
    .ent_addr (mem_req_addr)
  );

  assign present = mem_rsp_data[PTE_BIT_V];
  assign accept  = (st == ST_IDLE) && miss_valid;
  assign l1_take = (st == ST_L1_WAIT) && mem_rsp_valid;
  assign l2_take = (st == ST_L2_WAIT) && mem_rsp_valid;

  // Walk datapath: one base register reused for both table levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      ppn_q  <= '0;
      perm_q <= '0;
      lvl_q  <= FLT_NONE;
    end else begin
      if (accept) begin
        va_q   <= miss_vaddr;
        base_q <= root_q;
      end
      if (l1_take) begin
        if (present) base_q <= mem_rsp_data[PA_W-1:OFF_W];
        else         lvl_q  <= FLT_L1;
      end
      if (l2_take) begin
        if (present) begin
          ppn_q  <= mem_rsp_data[PA_W-1:OFF_W];
          perm_q <= {mem_rsp_data[PTE_BIT_U], mem_rsp_data[PTE_BIT_D],
                     mem_rsp_data[PTE_BIT_W], mem_rsp_data[PTE_BIT_R]};
        end else begin
          lvl_q  <= FLT_L2;
        end
      end
    end
  end

  assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:PTE_BIT_U+1];

  assign miss_ready    = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign mem_rsp_ready = (st == ST_L1_WAIT) || (st == ST_L2_WAIT);
  assign refill_valid  = (st == ST_REFILL);
  assign refill_vpn    = va_q[VA_W-1:OFF_W];
  assign refill_ppn    = ppn_q;
  assign refill_perm   = perm_q;
  assign fault_valid   = (st == ST_FAULT);
  assign fault_vaddr   = va_q;
  assign fault_level   = lvl_q;
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_valid,
  input logic        miss_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_ready,
  input logic        refill_valid,
  input logic        refill_ready,
  input logic [19:0] refill_vpn,
  input logic [19:0] refill_ppn,
  input logic [3:0]  refill_perm,
  input logic        fault_valid,
  input logic        fault_ready,
  input logic [31:0] fault_vaddr,
  input logic [1:0]  fault_level
);
  assert_one_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_ready, mem_req_valid, mem_rsp_ready, refill_valid, fault_valid}));

  assert_first_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> mem_req_valid);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_refill_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !refill_ready) |=>
      (refill_valid && $stable(refill_vpn) && $stable(refill_ppn) && $stable(refill_perm)));

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_ready) |=>
      (fault_valid && $stable(fault_vaddr) && $stable(fault_level)));

  assert_fault_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_level == 2'd1 || fault_level == 2'd2));

  assert_back_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((refill_valid && refill_ready) || (fault_valid && fault_ready)) |=> miss_ready);
endmodule

bind ptw_top ptw_top_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .refill_valid  (refill_valid),
  .refill_ready  (refill_ready),
  .refill_vpn    (refill_vpn),
  .refill_ppn    (refill_ppn),
  .refill_perm   (refill_perm),
  .fault_valid   (fault_valid),
  .fault_ready   (fault_ready),
  .fault_vaddr   (fault_vaddr),
  .fault_level   (fault_level)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        root_load = 0;
  logic [19:0] root_ppn = '0;
  logic        miss_valid = 0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        refill_valid;
  logic        refill_ready = 0;
  logic [19:0] refill_vpn;
  logic [19:0] refill_ppn;
  logic [3:0]  refill_perm;
  logic        fault_valid;
  logic        fault_ready = 0;
  logic [31:0] fault_vaddr;
  logic [1:0]  fault_level;

  ptw_top dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] mem [0:4095];
  int          req_stall = 0;
  int          rsp_lat = 0;
  int          n_req = 0;
  logic [31:0] addr_log [0:3];

  bit          got_refill, got_fault, busy_bad, stable_bad;
  logic [19:0] cap_vpn, cap_ppn;
  logic [3:0]  cap_perm;
  logic [31:0] cap_fva;
  logic [1:0]  cap_lvl;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // Memory model: stalls requests, delays responses
  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (rst_n && mem_req_valid) begin
        logic [31:0] a;
        repeat (req_stall) @(negedge clk);
        mem_req_ready = 1;
        a = mem_req_addr;
        if (n_req < 4) addr_log[n_req] = a;
        n_req++;
        @(negedge clk);
        mem_req_ready = 0;
        repeat (rsp_lat) @(negedge clk);
        chk("R4", "rsp_ready while awaiting", {31'b0, mem_rsp_ready}, 32'd1);
        mem_rsp_valid = 1;
        mem_rsp_data = mem[a[13:2]];
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic set_root(input logic [19:0] p);
    @(negedge clk);
    root_load = 1;
    root_ppn = p;
    @(negedge clk);
    root_load = 0;
  endtask

  task automatic run_miss(input logic [31:0] va, input int hold);
    int k;
    n_req = 0;
    busy_bad = 0;
    stable_bad = 0;
    @(negedge clk);
    miss_valid = 1;
    miss_vaddr = va;
    @(negedge clk);
    miss_valid = 0;
    miss_vaddr = 32'hDEAD_BEEF;
    chk("R2", "miss_ready after accept", {31'b0, miss_ready}, 32'd0);
    k = 0;
    while (!(refill_valid || fault_valid) && k < 300) begin
      @(negedge clk);
      k++;
      if (miss_ready) busy_bad = 1;
    end
    got_refill = refill_valid;
    got_fault = fault_valid;
    cap_vpn = refill_vpn;
    cap_ppn = refill_ppn;
    cap_perm = refill_perm;
    cap_fva = fault_vaddr;
    cap_lvl = fault_level;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (got_refill && !(refill_valid && refill_vpn == cap_vpn &&
                          refill_ppn == cap_ppn && refill_perm == cap_perm)) stable_bad = 1;
      if (got_fault && !(fault_valid && fault_vaddr == cap_fva && fault_level == cap_lvl)) stable_bad = 1;
    end
    refill_ready = got_refill;
    fault_ready = got_fault;
    @(negedge clk);
    refill_ready = 0;
    fault_ready = 0;
    chk("R2", "no ready during walk", {31'b0, busy_bad}, 32'd0);
    chk("R8", "idle after handoff", {31'b0, miss_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1", "miss_ready", {31'b0, miss_ready}, 32'd1);
    chk("R1", "req/rsp/refill/fault", {28'b0, mem_req_valid, mem_rsp_ready, refill_valid, fault_valid}, 32'd0);
  endtask

  task automatic t_walk_ok();
    req_stall = 0;
    rsp_lat = 0;
    set_root(20'h00001);
    mem[12'h405] = 32'h0000_2001;
    mem[12'h807] = 32'hABCD_E01B;
    run_miss(32'h0140_7345, 0);
    chk("R3", "first address", addr_log[0], 32'h0000_1014);
    chk("R6", "second address", addr_log[1], 32'h0000_201C);
    chk("R8", "refill taken", {31'b0, got_refill}, 32'd1);
    chk("R8", "vpn", {12'b0, cap_vpn}, 32'h0001_407);
    chk("R8", "ppn", {12'b0, cap_ppn}, 32'h000A_BCDE);
    chk("R8", "perm", {28'b0, cap_perm}, 32'hD);
  endtask

  task automatic t_edge_slow();
    req_stall = 3;
    rsp_lat = 5;
    mem[12'h7FF] = 32'h0000_0001;
    mem[12'h3FF] = 32'h1234_5007;
    run_miss(32'hFFFF_FFFF, 4);
    chk("R4", "first address stalled", addr_log[0], 32'h0000_1FFC);
    chk("R6", "second address top index", addr_log[1], 32'h0000_0FFC);
    chk("R8", "ppn slow", {12'b0, cap_ppn}, 32'h0001_2345);
    chk("R8", "perm slow", {28'b0, cap_perm}, 32'h3);
    chk("R8", "held under back-pressure", {31'b0, stable_bad}, 32'd0);
  endtask

  task automatic t_l1_fault();
    req_stall = 1;
    rsp_lat = 2;
    run_miss(32'h0240_0ABC, 0);
    chk("R5", "fault raised", {30'b0, got_fault, got_refill}, 32'h2);
    chk("R5", "fault level", {30'b0, cap_lvl}, 32'd1);
    chk("R5", "fault vaddr", cap_fva, 32'h0240_0ABC);
    chk("R5", "single request", n_req, 32'd1);
  endtask

  task automatic t_l2_fault();
    req_stall = 0;
    rsp_lat = 1;
    mem[12'h808] = 32'hFFFF_F01E;
    run_miss(32'h0140_8010, 3);
    chk("R7", "fault raised", {30'b0, got_fault, got_refill}, 32'h2);
    chk("R7", "fault level", {30'b0, cap_lvl}, 32'd2);
    chk("R7", "second address", addr_log[1], 32'h0000_2020);
    chk("R9", "fault vaddr", cap_fva, 32'h0140_8010);
    chk("R9", "held under back-pressure", {31'b0, stable_bad}, 32'd0);
  endtask

  task automatic t_root_switch();
    req_stall = 4;
    rsp_lat = 0;
    mem[12'hC05] = 32'h0000_0001;
    mem[12'h007] = 32'h0BEE_F003;
    fork
      run_miss(32'h0140_7345, 0);
      begin
        repeat (3) @(negedge clk);
        root_load = 1;
        root_ppn = 20'h00003;
        @(negedge clk);
        root_load = 0;
      end
    join
    chk("R10", "walk keeps old root", addr_log[0], 32'h0000_1014);
    chk("R10", "old-root refill ppn", {12'b0, cap_ppn}, 32'h000A_BCDE);
    req_stall = 0;
    run_miss(32'h0140_7345, 0);
    chk("R10", "next walk uses new root", addr_log[0], 32'h0000_3014);
    chk("R10", "new-root second address", addr_log[1], 32'h0000_001C);
    chk("R10", "new-root ppn", {12'b0, cap_ppn}, 32'h0000_BEEF);
    chk("R8", "new-root perm", {28'b0, cap_perm}, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_walk_ok();
    t_edge_slow();
    t_l1_fault();
    t_l2_fault();
    t_root_switch();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule